// File: doc/BRIEF.md
# Timer Compare-Match Output Unit

This block turns the compare events of a small up/down timer into one waveform bit and places that bit on a general-purpose I/O pin. Every cycle it compares the counter value it is given against a compare value. When the two are equal on a cycle where the timer clock enable is high, it updates an internal output flip-flop. The two-bit action field decides whether the flip-flop keeps its value, toggles, clears or sets. A force strobe applies the same action at any time without a counter match. The counter, its prescaler and any waveform shaping sit outside the block. The counter and compare values are plain inputs.

A write to the counter must not cause a spurious event. A small gate state machine therefore suppresses match detection in the cycle of the write and on the first timer-enabled cycle after it. The machine has two states. `GATE_ARMED` allows matches. `GATE_MUTED` suppresses them. It moves from ARMED to MUTED on a counter-write strobe. It moves from MUTED to ARMED on a timer-enabled cycle that carries no new write. A write in MUTED keeps it in MUTED. In any other case it stays where it is. The action field is not buffered. While the field is non-zero, the pin value comes from the flip-flop. While it is zero, the pin value comes from the port data bit. The output enable always follows the port direction bit.

Top module: `cmpout_unit`

## Requirements
- R1: During reset and after it the output flip-flop is 0 and the gate is ARMED. With action field 00 the pin value equals the port data bit.
- R2: An event occurs when `tick` is 1, `cnt_val` equals `cmp_val` and the gate allows it. The flip-flop takes its new value at that same clock edge. With `tick` at 0, equal values cause no event.
- R3: The action field `act_mode` encodes what an event does to the flip-flop: 00 keep, 01 toggle, 10 clear to 0, 11 set to 1.
- R4: A match is suppressed in any cycle with `cnt_wr` high. It is also suppressed on the first `tick` cycle after the write, however many cycles without `tick` come between. The `tick` cycle after that detects matches again.
- R5: `force_cmp` causes an event in any cycle, with or without `tick`, using the current action field. It neither starts nor ends the write suppression.
- R6: When a match and a force occur in the same cycle, the flip-flop is updated only once.
- R7: `pin_out` equals the flip-flop whenever `act_mode` is non-zero and equals `port_dat` when it is 00. A change of `act_mode` shows up at the pin in the cycle it is applied, with no wait for a counter boundary.
- R8: `pin_oe` always equals `port_dir`, whatever the action field is.
- R9: The flip-flop keeps its value when `act_mode` changes. Only an event or a reset alters it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock enable |
| cnt_val | input | CNT_W | Current counter value |
| cmp_val | input | CNT_W | Compare value |
| cnt_wr | input | 1 | Counter-write strobe |
| force_cmp | input | 1 | Force-compare strobe |
| act_mode | input | 2 | Compare action field (00 keep, 01 toggle, 10 clear, 11 set) |
| port_dat | input | 1 | Port data bit for the pin |
| port_dir | input | 1 | Port direction bit (1 = output) |
| pin_out | output | 1 | Value driven toward the pin |
| pin_oe | output | 1 | Pin output enable |

## Verification
The bench builds the block with `CNT_W` set to 4. Random counter and compare values then match about once in sixteen cycles, so a few hundred random steps cover many matches. Those steps also land matches inside and outside the write-suppression window, alongside forces and action-field changes. With the narrow counter the bench can also place the counter exactly on the compare value at the cycle of a write and at the first `tick` after it. These are the cases R4 turns on.

// File: rtl/cmpout_pkg.sv
package cmpout_pkg;

    // Action taken on the output flip-flop at an event
    typedef enum logic [1:0] {
        ACT_KEEP   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } oc_act_e;

    // Match gate after a counter write
    typedef enum logic {
        GATE_ARMED = 1'b0,
        GATE_MUTED = 1'b1
    } gate_st_e;

endpackage

// File: rtl/cmpout_gate.sv
module cmpout_gate
    import cmpout_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cnt_wr,
    output logic allow
);

    gate_st_e state_q;
    gate_st_e state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_ARMED: if (cnt_wr) state_d = GATE_MUTED;
            GATE_MUTED: begin
                if (cnt_wr)    state_d = GATE_MUTED;
                else if (tick) state_d = GATE_ARMED;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_ARMED;
        else        state_q <= state_d;
    end

    // Output process: a write cycle is itself blocked
    always_comb begin
        allow = 1'b0;
        unique case (state_q)
            GATE_ARMED: allow = !cnt_wr;
            GATE_MUTED: allow = 1'b0;
        endcase
    end

    // R4: a muted gate re-arms on a tick with no new write
    p_rearm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GATE_MUTED && tick && !cnt_wr) |=> (state_q == GATE_ARMED));

    // R4: any write leaves the gate muted
    p_mute_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (state_q == GATE_MUTED));

endmodule

// File: rtl/cmpout_action.sv
module cmpout_action
    import cmpout_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       cur,
    output logic       nxt
);

    oc_act_e act;
    assign act = oc_act_e'(mode);

    always_comb begin
        nxt = cur;
        unique case (act)
            ACT_KEEP:   nxt = cur;
            ACT_TOGGLE: nxt = !cur;
            ACT_CLEAR:  nxt = 1'b0;
            ACT_SET:    nxt = 1'b1;
        endcase
    end

endmodule

// File: rtl/cmpout_unit.sv
module cmpout_unit
    import cmpout_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             cnt_wr,
    input  logic             force_cmp,
    input  logic [1:0]       act_mode,
    input  logic             port_dat,
    input  logic             port_dir,
    output logic             pin_out,
    output logic             pin_oe
);

    logic allow;
    logic raw_match;
    logic event_hit;
    logic oc_q;
    logic oc_nxt;

    cmpout_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .cnt_wr (cnt_wr),
        .allow  (allow)
    );

    cmpout_action u_act (
        .mode (act_mode),
        .cur  (oc_q),
        .nxt  (oc_nxt)
    );

    assign raw_match = tick && (cnt_val == cmp_val);
    // A match and a force merge into one update
    assign event_hit = (raw_match && allow) || force_cmp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         oc_q <= 1'b0;
        else if (event_hit) oc_q <= oc_nxt;
    end

    // Pin override selected by the action field only
    assign pin_out = (act_mode != ACT_KEEP) ? oc_q : port_dat;
    assign pin_oe  = port_dir;

    // R9: without a match or force the flip-flop holds
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!raw_match && !force_cmp) |=> $stable(oc_q));

    // R4: a write cycle never produces a match on its own
    p_wr_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && !force_cmp) |=> $stable(oc_q));

    // R5: force with set action
    p_force_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (force_cmp && act_mode == 2'b11) |=> oc_q);

    // R5: force with clear action
    p_force_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (force_cmp && act_mode == 2'b10) |=> !oc_q);

    // R6: toggle with force flips exactly once
    p_single_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (force_cmp && act_mode == 2'b01) |=> (oc_q != $past(oc_q)));

endmodule

// File: tb/tb_cmpout_unit.sv
module tb_cmpout_unit;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic [W-1:0] cnt_val = '0;
    logic [W-1:0] cmp_val = '0;
    logic         cnt_wr = 1'b0;
    logic         force_cmp = 1'b0;
    logic [1:0]   act_mode = 2'b00;
    logic         port_dat = 1'b0;
    logic         port_dir = 1'b0;
    logic         pin_out;
    logic         pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Scoreboard: expected {pin_out, pin_oe} plus requirement tag
    logic [1:0] exp_q[$];
    string      tag_q[$];

    // Reference model state
    logic m_oc = 1'b0;
    logic m_mute = 1'b0;

    always #5 clk = ~clk;

    cmpout_unit #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_val(cnt_val),
        .cmp_val(cmp_val), .cnt_wr(cnt_wr), .force_cmp(force_cmp),
        .act_mode(act_mode), .port_dat(port_dat), .port_dir(port_dir),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic step(input logic r, input logic k, input logic [W-1:0] c,
                        input logic [W-1:0] p, input logic wr, input logic f,
                        input logic [1:0] m, input logic pd, input logic dr,
                        input string tag);
        logic hit;
        @(negedge clk);
        rst_n = r; tick = k; cnt_val = c; cmp_val = p; cnt_wr = wr;
        force_cmp = f; act_mode = m; port_dat = pd; port_dir = dr;
        if (!r) begin
            m_oc = 1'b0;
            m_mute = 1'b0;
        end else begin
            hit = (k && c == p && !m_mute && !wr) || f;
            if (hit) begin
                case (m)
                    2'b01: m_oc = !m_oc;
                    2'b10: m_oc = 1'b0;
                    2'b11: m_oc = 1'b1;
                    default: m_oc = m_oc;
                endcase
            end
            if (wr)     m_mute = 1'b1;
            else if (k) m_mute = 1'b0;
        end
        exp_q.push_back({(m != 2'b00) ? m_oc : pd, dr});
        tag_q.push_back(tag);
    endtask

    // Monitor: compares after each edge, away from it
    always begin
        logic [1:0] e;
        string t;
        @(posedge clk);
        #2;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({pin_out, pin_oe} !== e) begin
                errors++;
                $display("FAIL %s: pin_out/pin_oe = %b%b expected %b%b",
                         t, pin_out, pin_oe, e[1], e[0]);
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, port data drives the pin
        step(0, 0, 0, 0, 0, 0, 2'b00, 1, 1, "R1 reset port");
        step(0, 1, 5, 5, 0, 1, 2'b00, 0, 1, "R1 reset hold");
        // R1/R7: flip-flop is 0 after reset, visible with set action
        step(1, 1, 3, 5, 0, 0, 2'b11, 1, 1, "R1 oc zero");
        // R2: equal values without tick do nothing
        step(1, 0, 5, 5, 0, 0, 2'b11, 1, 1, "R2 no tick");
        // R2/R3: match with set
        step(1, 1, 5, 5, 0, 0, 2'b11, 0, 1, "R3 set");
        step(1, 1, 5, 5, 0, 0, 2'b10, 1, 1, "R3 clear");
        step(1, 1, 5, 5, 0, 0, 2'b01, 0, 1, "R3 toggle up");
        step(1, 1, 5, 5, 0, 0, 2'b01, 0, 1, "R3 toggle down");
        // R3 keep and R7 port source
        step(1, 1, 5, 5, 0, 0, 2'b00, 1, 1, "R7 port source");
        // R9: mode change does not alter the flip-flop
        step(1, 0, 5, 5, 0, 0, 2'b11, 1, 1, "R9 retain low");
        // R4: write suppression
        step(1, 1, 5, 5, 1, 0, 2'b01, 0, 1, "R4 write cycle");
        step(1, 0, 5, 5, 0, 0, 2'b01, 0, 1, "R4 idle muted");
        step(1, 0, 5, 5, 0, 0, 2'b01, 0, 1, "R4 idle muted 2");
        step(1, 1, 5, 5, 0, 0, 2'b01, 0, 1, "R4 first tick blocked");
        step(1, 1, 5, 5, 0, 0, 2'b01, 0, 1, "R4 second tick match");
        // R5: force without tick
        step(1, 0, 1, 9, 0, 1, 2'b10, 1, 1, "R5 force clear");
        step(1, 0, 1, 9, 1, 0, 2'b01, 1, 1, "R5 write");
        step(1, 0, 1, 9, 0, 1, 2'b11, 1, 1, "R5 force while muted");
        step(1, 1, 9, 9, 0, 0, 2'b01, 1, 1, "R5 still muted");
        step(1, 1, 9, 9, 0, 0, 2'b01, 1, 1, "R5 rearmed");
        // R6: coincident match and force toggle once
        step(1, 1, 7, 7, 0, 1, 2'b01, 0, 1, "R6 single update");
        step(1, 1, 7, 7, 0, 1, 2'b01, 0, 1, "R6 single update 2");
        // R8: direction only from port_dir
        step(1, 0, 0, 1, 0, 0, 2'b11, 1, 0, "R8 input dir");
        step(1, 0, 0, 1, 0, 0, 2'b00, 1, 0, "R8 input dir port");
        // R7: immediate mode switch both ways
        step(1, 0, 0, 1, 0, 0, 2'b10, 1, 1, "R7 switch to oc");
        step(1, 0, 0, 1, 0, 0, 2'b00, 0, 1, "R7 switch to port");
        // Random mix covering R2 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < 400; i++) begin
            logic k, wr, f;
            k  = ($urandom % 3) != 0;
            wr = ($urandom % 8) == 0;
            f  = ($urandom % 10) == 0;
            step(1, k, W'($urandom), W'($urandom % 4), wr, f,
                 2'($urandom), 1'($urandom), 1'($urandom), "R2 R4 R5 random");
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule